// File: doc/BRIEF.md
# Reset Cause Flag Register

This block is a status register that software reads to learn why the device last came out of reset or entered a low-power state. Single-cycle strobes from the reset and power-management logic each set their own flag. The strobes are power-on, brown-out, external pin reset, software reset command, configuration mismatch, watchdog timeout, and a wait instruction qualified by a sleep/idle select. A register-bus write port lets software set or clear any implemented flag by writing the whole word. The full word is always visible on the output.

The flags do not all follow the same rule. The power-on and brown-out flags are sticky: power events set them, and only a software write clears them. Every other flag is wiped by either power event. A power event applies its clear first and then its own sets, so after a power-on only the two power flags remain.

Top module: `rcause_reg`

## Requirements
- R1: While reset is asserted, and after it is released with no events or writes, every bit of `status_o` reads 0.
- R2: Flag positions in `status_o`: power-on bit 0, brown-out bit 1, idle bit 2, sleep bit 3, watchdog bit 4, software reset bit 6, external pin reset bit 7, configuration mismatch bit 9.
- R3: A power-on strobe sets bits 0 and 1. A brown-out strobe sets bit 1 and leaves bit 0 unchanged.
- R4: A power-on or brown-out strobe never clears bit 0 or bit 1.
- R5: A power-on or brown-out strobe clears bits 2, 3, 4, 6, 7 and 9, unless a hardware strobe sets that bit in the same cycle.
- R6: The external reset, software reset, configuration mismatch and watchdog strobes each set their flag in the cycle after the strobe.
- R7: A wait strobe sets bit 3 (sleep) when `wait_sleep` is 1 and bit 2 (idle) when it is 0. The other bit is left unchanged.
- R8: When `wr_en` is 1, every implemented flag takes the value of the matching `wr_data` bit on the next cycle.
- R9: Bits 5, 8 and 10 and above always read 0, and writes to them have no effect.
- R10: If a hardware strobe and a software write of 0 hit the same bit in the same cycle, the bit ends up 1.
- R11: With no strobe and no write, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ev_por | input | 1 | Power-on event strobe |
| ev_bor | input | 1 | Brown-out event strobe |
| ev_extr | input | 1 | External pin reset strobe |
| ev_swr | input | 1 | Software reset command strobe |
| ev_cfgmm | input | 1 | Configuration mismatch strobe |
| ev_wdt | input | 1 | Watchdog timeout strobe |
| ev_wait | input | 1 | Wait instruction executed |
| wait_sleep | input | 1 | Low-power mode select at wait time: 1 sleep, 0 idle |
| wr_en | input | 1 | Software write enable |
| wr_data | input | WIDTH | Software write value |
| status_o | output | WIDTH | Flag word |

## Verification
Every strobe and every write affects `status_o` exactly one clock edge later, because one register stage sits between the inputs and the output. After reset is released, the internal reset stays active for two more edges. The bench drives inputs on the falling edge. It advances its reference model at the next rising edge and compares at the following falling edge, so each result is sampled in the cycle it is due. The bench waits out the reset synchronizer before the first stimulus.

// File: rtl/rcause_pkg.sv
package rcause_pkg;
  localparam int unsigned BIT_POR   = 0;
  localparam int unsigned BIT_BOR   = 1;
  localparam int unsigned BIT_IDLE  = 2;
  localparam int unsigned BIT_SLEEP = 3;
  localparam int unsigned BIT_WDT   = 4;
  localparam int unsigned BIT_SWR   = 6;
  localparam int unsigned BIT_EXTR  = 7;
  localparam int unsigned BIT_CFG   = 9;
  localparam int unsigned MIN_WIDTH = 10;

  function automatic bit is_flag(int unsigned b);
    return (b == BIT_POR) || (b == BIT_BOR) || (b == BIT_IDLE) ||
           (b == BIT_SLEEP) || (b == BIT_WDT) || (b == BIT_SWR) ||
           (b == BIT_EXTR) || (b == BIT_CFG);
  endfunction

  function automatic bit is_power_flag(int unsigned b);
    return (b == BIT_POR) || (b == BIT_BOR);
  endfunction
endpackage

// File: rtl/rcause_rst_sync.sv
module rcause_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rcause_event_map.sv
module rcause_event_map
  import rcause_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             ev_por,
  input  logic             ev_bor,
  input  logic             ev_extr,
  input  logic             ev_swr,
  input  logic             ev_cfgmm,
  input  logic             ev_wdt,
  input  logic             ev_wait,
  input  logic             wait_sleep,
  output logic [WIDTH-1:0] hw_set,
  output logic             pwr_clr
);
  always_comb begin
    hw_set            = '0;
    hw_set[BIT_POR]   = ev_por;
    hw_set[BIT_BOR]   = ev_por | ev_bor;
    hw_set[BIT_IDLE]  = ev_wait & ~wait_sleep;
    hw_set[BIT_SLEEP] = ev_wait & wait_sleep;
    hw_set[BIT_WDT]   = ev_wdt;
    hw_set[BIT_SWR]   = ev_swr;
    hw_set[BIT_EXTR]  = ev_extr;
    hw_set[BIT_CFG]   = ev_cfgmm;
    pwr_clr           = ev_por | ev_bor;
  end
endmodule

// File: rtl/rcause_flag_cell.sv
module rcause_flag_cell #(
  parameter bit KEEP_ON_POWER = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic pwr_clr_i,
  input  logic we_i,
  input  logic wd_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  // priority: software value, then power clear, then hardware set
  always_comb begin
    q_d = q_o;
    if (we_i) q_d = wd_i;
    if (pwr_clr_i && !KEEP_ON_POWER) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
    q_en = we_i | set_i | pwr_clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= 1'b0;
    else if (q_en) q_o <= q_d;
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_i || pwr_clr_i || we_i) |=> $stable(q_o));

  generate
    if (KEEP_ON_POWER) begin : g_keep
      // R4
      power_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_clr_i && !we_i && q_o) |=> q_o);
    end else begin : g_wipe
      // R5
      power_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_clr_i && !set_i) |=> !q_o);
    end
  endgenerate
endmodule

// File: rtl/rcause_reg.sv
module rcause_reg
  import rcause_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_por,
  input  logic             ev_bor,
  input  logic             ev_extr,
  input  logic             ev_swr,
  input  logic             ev_cfgmm,
  input  logic             ev_wdt,
  input  logic             ev_wait,
  input  logic             wait_sleep,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] status_o
);
  logic             rst_q_n;
  logic [WIDTH-1:0] hw_set;
  logic             pwr_clr;

  rcause_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  rcause_event_map #(.WIDTH(WIDTH)) u_event_map (
    .ev_por     (ev_por),
    .ev_bor     (ev_bor),
    .ev_extr    (ev_extr),
    .ev_swr     (ev_swr),
    .ev_cfgmm   (ev_cfgmm),
    .ev_wdt     (ev_wdt),
    .ev_wait    (ev_wait),
    .wait_sleep (wait_sleep),
    .hw_set     (hw_set),
    .pwr_clr    (pwr_clr)
  );

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (is_flag(i)) begin : g_flag
        rcause_flag_cell #(.KEEP_ON_POWER(is_power_flag(i))) u_cell (
          .clk       (clk),
          .rst_n     (rst_q_n),
          .set_i     (hw_set[i]),
          .pwr_clr_i (pwr_clr),
          .we_i      (wr_en),
          .wd_i      (wr_data[i]),
          .q_o       (status_o[i])
        );
      end else begin : g_none
        logic unused_wr_bit;
        assign unused_wr_bit = wr_data[i];
        assign status_o[i]   = 1'b0;
      end
    end
  endgenerate

  // R3
  por_sets_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ev_por |=> (status_o[BIT_POR] && status_o[BIT_BOR]));

  // R7
  wait_sleep_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ev_wait && wait_sleep) |=> status_o[BIT_SLEEP]);

  // R7
  wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ev_wait && !wait_sleep) |=> status_o[BIT_IDLE]);
endmodule

// File: tb/rcause_reg_bench.sv
module rcause_reg_bench;
  localparam int W = 32;
  localparam logic [W-1:0] IMPL = 32'h0000_02DF;

  logic clk = 1'b0;
  logic rst_n;
  logic ev_por, ev_bor, ev_extr, ev_swr, ev_cfgmm, ev_wdt, ev_wait, wait_sleep, wr_en;
  logic [W-1:0] wr_data;
  logic [W-1:0] status_o;
  logic [W-1:0] model;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rcause_reg #(.WIDTH(W)) u_rcause_reg (
    .clk(clk), .rst_n(rst_n), .ev_por(ev_por), .ev_bor(ev_bor), .ev_extr(ev_extr),
    .ev_swr(ev_swr), .ev_cfgmm(ev_cfgmm), .ev_wdt(ev_wdt), .ev_wait(ev_wait),
    .wait_sleep(wait_sleep), .wr_en(wr_en), .wr_data(wr_data), .status_o(status_o)
  );

  task automatic check(input string tag);
    checks++;
    if (status_o !== model) begin
      failures++;
      $display("FAIL %s: status=%h expected=%h", tag, status_o, model);
    end
  endtask

  // ev = {por,bor,extr,swr,cfg,wdt,wait}
  task automatic step(input logic [6:0] ev, input logic mode, input logic we,
                      input logic [W-1:0] wd, input string tag);
    {ev_por, ev_bor, ev_extr, ev_swr, ev_cfgmm, ev_wdt, ev_wait} = ev;
    wait_sleep = mode; wr_en = we; wr_data = wd;
    @(posedge clk);
    if (we) model = (model & ~IMPL) | (wd & IMPL);
    if (ev[6] || ev[5]) model = model & 32'h3;
    if (ev[6]) model = model | 32'h3;
    if (ev[5]) model = model | 32'h2;
    if (ev[4]) model = model | (32'h1 << 7);
    if (ev[3]) model = model | (32'h1 << 6);
    if (ev[2]) model = model | (32'h1 << 9);
    if (ev[1]) model = model | (32'h1 << 4);
    if (ev[0]) model = model | (mode ? 32'h8 : 32'h4);
    @(negedge clk);
    {ev_por, ev_bor, ev_extr, ev_swr, ev_cfgmm, ev_wdt, ev_wait} = '0;
    wait_sleep = 1'b0; wr_en = 1'b0; wr_data = '0;
    check(tag);
  endtask

  initial begin
    {ev_por, ev_bor, ev_extr, ev_swr, ev_cfgmm, ev_wdt, ev_wait} = '0;
    wait_sleep = 0; wr_en = 0; wr_data = '0; model = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 after release");
    step(7'b1000000, 0, 0, '0, "R3 R2 power-on sets bits 0,1");
    step(7'b0000000, 0, 1, '0, "R8 write zero");
    step(7'b0100000, 0, 0, '0, "R3 brown-out sets bit 1 only");
    step(7'b0010000, 0, 0, '0, "R6 R2 external reset bit 7");
    step(7'b0001000, 0, 0, '0, "R6 R2 software reset bit 6");
    step(7'b0000100, 0, 0, '0, "R6 R2 config mismatch bit 9");
    step(7'b0000010, 0, 0, '0, "R6 R2 watchdog bit 4");
    step(7'b0000001, 1, 0, '0, "R7 wait sleep bit 3");
    step(7'b0000001, 0, 0, '0, "R7 wait idle bit 2");
    for (int k = 0; k < 3; k++) step(7'b0, 0, 0, '0, "R11 hold");
    step(7'b1000000, 0, 0, '0, "R5 R4 power-on wipes others");
    step(7'b0000000, 0, 1, '1, "R9 R8 write all ones");
    step(7'b0100000, 0, 0, '0, "R5 R4 brown-out keeps power flags");
    step(7'b0000000, 0, 1, 32'hFFFF_FD20, "R9 unused bits ignore writes");
    step(7'b0000010, 0, 1, '0, "R10 set beats write zero");
    step(7'b0000001, 1, 1, 32'h4, "R10 R7 wait with write");
    step(7'b1000010, 0, 0, '0, "R5 same-cycle set survives clear");
    step(7'b0000000, 0, 1, 32'h0000_0203, "R8 partial write");
    step(7'b0000000, 0, 1, '0, "R8 clear all");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: status=%h expected=%h", status_o, model);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule